// File: doc/BRIEF.md
# Scaled Watchdog Timer with Sticky Status

This block is a byte-wide down-counting watchdog that sits behind a configuration port with an index bus, a write strobe and a combinational read-data path. Software arms it by writing a nonzero count, which is then decremented on a 1 Hz tick input. Each decrement takes either one tick (second mode) or sixty ticks (minute mode). Writing zero to the count register disarms it.

When the count runs out, or when software or the keyboard controller forces a timeout, the block sets a sticky fired flag. That flag drives a level interrupt output and the block also offers a fixed-length keyboard-reset pulse. The interrupt number to route is exported unchanged for an external controller.

Keyboard and mouse interrupt activity can be enabled to keep the watchdog alive. Each cycle such an interrupt is high reloads the counter from the last value software wrote.

Top module: `wdt_scaled_top`

## Requirements
- R1: After reset, reads of index 0xF5, 0xF6 and 0xF7 return 0x00, and `wdt_irq_o`, `kbd_rst_o` and `wdt_irq_sel_o` are low.
- R2: Writing a nonzero byte to index 0xF6 loads and arms the counter, and rewriting it reloads the counter; reading 0xF6 returns the live count. Writing 0x00 disarms the counter, after which ticks neither change it nor cause a timeout.
- R3: With bit 3 of 0xF5 at 0 (second mode), each tick pulse decrements an armed count by exactly one.
- R4: With bit 3 of 0xF5 at 1 (minute mode), an armed count decrements once every 60 ticks. Every load or reload restarts that 60-tick window.
- R5: When the count steps from 1 to 0, bit 4 of 0xF7 (fired) reads 1 and `wdt_irq_o` rises. The counter then holds 0 on further ticks.
- R6: The fired flag is sticky. Writing 0xF7 with bit 4 at 0 clears it, and writing bit 4 as 1 leaves it unchanged.
- R7: Writing 0xF7 with bit 5 at 1 causes an immediate timeout: the count becomes 0 and fired is set. Bit 5 always reads 0.
- R8: On a timeout with bit 1 of 0xF5 at 1, `kbd_rst_o` is high for exactly 4 clock cycles; with that bit at 0 it stays low.
- R9: With bit 2 of 0xF5 at 1, a rising edge on `kbd_p20_i` causes a timeout. With that bit at 0, the input has no effect on the count or on fired.
- R10: With bit 6 (keyboard) or bit 7 (mouse) of 0xF7 at 1, each cycle the matching interrupt input is high reloads an armed counter with the last value written to 0xF6. With the enable bit at 0, that input has no effect.
- R11: Bits 3:0 of 0xF7 read back as written and drive `wdt_irq_sel_o`. Bits 7 and 6 of 0xF7 read back as written. In 0xF5, only bits 3, 2 and 1 are kept and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 8 | Register index |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for `cfg_idx_i` (combinational) |
| tick_i | input | 1 | One-cycle pulse per second |
| kbd_irq_i | input | 1 | Keyboard interrupt activity |
| mouse_irq_i | input | 1 | Mouse interrupt activity |
| kbd_p20_i | input | 1 | Keyboard controller force-timeout line |
| wdt_irq_o | output | 1 | Timeout interrupt level (follows fired flag) |
| wdt_irq_sel_o | output | 4 | Selected interrupt number (2 = SMI) |
| kbd_rst_o | output | 1 | Keyboard reset pulse on timeout |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- The 1-to-0 step: a design that decrements past zero would wrap to 0xFF, and one that misses the step would never raise fired.
- Minute mode at tick 59 versus tick 60: an off-by-one prescaler, or one not cleared by a rewrite, would move the decrement by a tick.
- Sticky fired under a write of 1 versus a write of 0: a design that treats the status register as plain storage would lose or keep the flag wrongly.
- Force, the P20 edge and interrupt-driven reload, each tried with its enable off as well as on: a design that ignores an enable would reload or fire on stray activity.
- The reset pulse is measured cycle by cycle: a pulse one cycle short or long is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // control register (index F5) field positions
  localparam int UNIT_BIT  = 3;
  localparam int P20_BIT   = 2;
  localparam int KBRST_BIT = 1;
  // status register (index F7) field positions
  localparam int MOUSE_BIT = 7;
  localparam int KBD_BIT   = 6;
  localparam int FORCE_BIT = 5;
  localparam int FIRED_BIT = 4;
  localparam int SEL_W     = 4;

  typedef struct packed {
    logic unit_min;
    logic p20_en;
    logic kbrst_en;
  } wdt_ctrl_t;

  typedef struct packed {
    logic             mouse_en;
    logic             kbd_en;
    logic [SEL_W-1:0] irq_sel;
  } wdt_stat_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic minute_i,
  output logic step_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap = (pre_q == PW'(DIV - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         pre_q <= '0;
        else if (clr_i)                      pre_q <= '0;
        else if (tick_i && run_i && minute_i) pre_q <= wrap ? '0 : pre_q + 1'b1;
      end

      assign step_o = tick_i && run_i && (!minute_i || wrap);
    end else begin : g_nodiv
      assign step_o = tick_i && run_i;
    end
  endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, reload_q;

  assign active_o = (count_q != '0);

  // priority: force > software load > activity reload > decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (force_i) begin
      count_q  <= '0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      reload_q <= load_val_i;
    end else if (reload_i && active_o) begin
      count_q  <= reload_q;
    end else if (dec_i && active_o) begin
      count_q  <= count_q - 1'b1;
    end
  end

  assign expire_o = dec_i && (count_q == CNT_W'(1)) && !force_i && !load_i && !reload_i;
  assign count_o  = count_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] cnt_q;

  // no retrigger while a pulse is in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (trig_i && cnt_q == '0)  cnt_q <= LW'(LEN);
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/wdt_scaled_top.sv
module wdt_scaled_top #(
  parameter int          DATA_W    = 8,
  parameter int          IDX_W     = 8,
  parameter int          MIN_TICKS = 60,
  parameter int          RST_LEN   = 4,
  parameter logic [7:0]  IDX_CTRL  = 8'hF5,
  parameter logic [7:0]  IDX_COUNT = 8'hF6,
  parameter logic [7:0]  IDX_STAT  = 8'hF7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              tick_i,
  input  logic              kbd_irq_i,
  input  logic              mouse_irq_i,
  input  logic              kbd_p20_i,
  output logic              wdt_irq_o,
  output logic [3:0]        wdt_irq_sel_o,
  output logic              kbd_rst_o
);
  import wdt_pkg::*;

  localparam int CNT_W = DATA_W;

  wdt_ctrl_t         ctrl_q;
  wdt_stat_t         stat_q;
  logic              fired_q;
  logic              p20_q;
  logic [CNT_W-1:0]  count;
  logic              active, expire, step;
  logic              wr_ctrl, wr_count, wr_stat;
  logic              force_evt, periph_reload, timeout_evt;

  assign wr_ctrl  = cfg_wr_i && (cfg_idx_i == IDX_W'(IDX_CTRL));
  assign wr_count = cfg_wr_i && (cfg_idx_i == IDX_W'(IDX_COUNT));
  assign wr_stat  = cfg_wr_i && (cfg_idx_i == IDX_W'(IDX_STAT));

  assign force_evt = (wr_stat && cfg_wdata_i[FORCE_BIT]) ||
                     (ctrl_q.p20_en && kbd_p20_i && !p20_q);

  assign periph_reload = (stat_q.kbd_en && kbd_irq_i) || (stat_q.mouse_en && mouse_irq_i);

  assign timeout_evt = force_evt || expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      fired_q <= 1'b0;
      p20_q   <= 1'b0;
    end else begin
      p20_q <= kbd_p20_i;
      if (wr_ctrl) begin
        ctrl_q.unit_min <= cfg_wdata_i[UNIT_BIT];
        ctrl_q.p20_en   <= cfg_wdata_i[P20_BIT];
        ctrl_q.kbrst_en <= cfg_wdata_i[KBRST_BIT];
      end
      if (wr_stat) begin
        stat_q.mouse_en <= cfg_wdata_i[MOUSE_BIT];
        stat_q.kbd_en   <= cfg_wdata_i[KBD_BIT];
        stat_q.irq_sel  <= cfg_wdata_i[SEL_W-1:0];
      end
      // timeout wins over a same-cycle clear
      if (timeout_evt)                           fired_q <= 1'b1;
      else if (wr_stat && !cfg_wdata_i[FIRED_BIT]) fired_q <= 1'b0;
    end
  end

  wdt_prescaler #(.DIV(MIN_TICKS)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wr_count || periph_reload || force_evt),
    .run_i    (active),
    .tick_i   (tick_i),
    .minute_i (ctrl_q.unit_min),
    .step_o   (step)
  );

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .force_i    (force_evt),
    .load_i     (wr_count),
    .load_val_i (cfg_wdata_i),
    .reload_i   (periph_reload),
    .dec_i      (step),
    .count_o    (count),
    .active_o   (active),
    .expire_o   (expire)
  );

  wdt_pulse #(.LEN(RST_LEN)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (timeout_evt && ctrl_q.kbrst_en),
    .pulse_o (kbd_rst_o)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_idx_i == IDX_W'(IDX_CTRL)) begin
      cfg_rdata_o[UNIT_BIT]  = ctrl_q.unit_min;
      cfg_rdata_o[P20_BIT]   = ctrl_q.p20_en;
      cfg_rdata_o[KBRST_BIT] = ctrl_q.kbrst_en;
    end else if (cfg_idx_i == IDX_W'(IDX_COUNT)) begin
      cfg_rdata_o = count;
    end else if (cfg_idx_i == IDX_W'(IDX_STAT)) begin
      cfg_rdata_o[MOUSE_BIT]   = stat_q.mouse_en;
      cfg_rdata_o[KBD_BIT]     = stat_q.kbd_en;
      cfg_rdata_o[FIRED_BIT]   = fired_q;
      cfg_rdata_o[SEL_W-1:0]   = stat_q.irq_sel;
    end
  end

  assign wdt_irq_o     = fired_q;
  assign wdt_irq_sel_o = stat_q.irq_sel;
endmodule

// File: rtl/wdt_scaled_chk.sv
module wdt_scaled_chk #(
  parameter int         DATA_W   = 8,
  parameter int         IDX_W    = 8,
  parameter int         RST_LEN  = 4,
  parameter logic [7:0] IDX_COUNT = 8'hF6,
  parameter logic [7:0] IDX_STAT  = 8'hF7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic [DATA_W-1:0] count,
  input logic              periph_reload,
  input logic              timeout_evt,
  input logic              fired_q,
  input logic              kbd_rst_o,
  input logic [3:0]        wdt_irq_sel_o
);
  localparam int RW = $clog2(RST_LEN + 2) + 1;
  logic [RW-1:0] run_len;
  logic wr_count, wr_stat;

  assign wr_count = cfg_wr_i && (cfg_idx_i == IDX_W'(IDX_COUNT));
  assign wr_stat  = cfg_wr_i && (cfg_idx_i == IDX_W'(IDX_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= '0;
    else if (kbd_rst_o) run_len <= (run_len == '1) ? run_len : run_len + 1'b1;
    else                run_len <= '0;
  end

  p_off_stays_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0 && !wr_count) |=> count == '0);

  p_no_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_count && !periph_reload) |=> count <= $past(count));

  p_expiry_fires_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_evt |=> fired_q);

  p_fired_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !(wr_stat && !cfg_wdata_i[4])) |=> fired_q);

  p_force_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx_i == IDX_W'(IDX_STAT)) |-> !cfg_rdata_o[5]);

  p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kbd_rst_o && run_len != '0) |-> run_len == RW'(RST_LEN));

  p_sel_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> $stable(wdt_irq_sel_o));
endmodule

bind wdt_scaled_top wdt_scaled_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .RST_LEN(RST_LEN),
  .IDX_COUNT(IDX_COUNT), .IDX_STAT(IDX_STAT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_idx_i     (cfg_idx_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .count         (count),
  .periph_reload (periph_reload),
  .timeout_evt   (timeout_evt),
  .fired_q       (fired_q),
  .kbd_rst_o     (kbd_rst_o),
  .wdt_irq_sel_o (wdt_irq_sel_o)
);

// File: tb/tb_wdt_scaled_top.sv
module tb_wdt_scaled_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_idx_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       tick_i = 1'b0;
  logic       kbd_irq_i = 1'b0;
  logic       mouse_irq_i = 1'b0;
  logic       kbd_p20_i = 1'b0;
  logic       wdt_irq_o;
  logic [3:0] wdt_irq_sel_o;
  logic       kbd_rst_o;

  int total = 0;
  int bad = 0;

  localparam logic [7:0] F_CTRL = 8'hF5, F_CNT = 8'hF6, F_STAT = 8'hF7;

  always #4 clk_i = ~clk_i;

  wdt_scaled_top dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    cfg_idx_i = idx; cfg_wdata_i = d; cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] idx, input int exp, input string tag);
    @(negedge clk_i);
    cfg_idx_i = idx;
    #1;
    check(tag, cfg_rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic pulse_in(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(F_CTRL, 8'h00, "R1 ctrl after reset");
    rd_chk(F_CNT, 8'h00, "R1 count after reset");
    rd_chk(F_STAT, 8'h00, "R1 status after reset");
    check("R1 outputs after reset", {wdt_irq_o, kbd_rst_o, wdt_irq_sel_o}, 0);
  endtask

  task automatic t_seconds();
    wr(F_CTRL, 8'h00);
    wr(F_CNT, 8'd3);
    rd_chk(F_CNT, 3, "R2 load arms count");
    ticks(1); rd_chk(F_CNT, 2, "R3 one tick one step");
    ticks(1); rd_chk(F_CNT, 1, "R3 second step");
    ticks(1); rd_chk(F_CNT, 0, "R5 reaches zero");
    rd_chk(F_STAT, 8'h10, "R5 fired bit set");
    check("R5 irq high", wdt_irq_o, 1);
    check("R8 no reset pulse when disabled", kbd_rst_o, 0);
    ticks(2); rd_chk(F_CNT, 0, "R5 holds at zero");
  endtask

  task automatic t_sticky();
    wr(F_STAT, 8'h10);
    rd_chk(F_STAT, 8'h10, "R6 write 1 keeps fired");
    wr(F_STAT, 8'h00);
    rd_chk(F_STAT, 8'h00, "R6 write 0 clears fired");
    check("R6 irq low after clear", wdt_irq_o, 0);
  endtask

  task automatic t_disable_reload();
    wr(F_CNT, 8'd0);
    ticks(3);
    rd_chk(F_CNT, 0, "R2 disabled no count");
    check("R2 disabled no timeout", wdt_irq_o, 0);
    wr(F_CNT, 8'd5);
    ticks(2); rd_chk(F_CNT, 3, "R3 counted down");
    wr(F_CNT, 8'd5);
    rd_chk(F_CNT, 5, "R2 rewrite reloads");
  endtask

  task automatic t_minute();
    wr(F_CTRL, 8'h08);
    rd_chk(F_CTRL, 8'h08, "R11 ctrl unit readback");
    wr(F_CNT, 8'd2);
    ticks(59); rd_chk(F_CNT, 2, "R4 no step at tick 59");
    ticks(1);  rd_chk(F_CNT, 1, "R4 step at tick 60");
    wr(F_CNT, 8'd2);
    ticks(30);
    wr(F_CNT, 8'd2);
    ticks(59); rd_chk(F_CNT, 2, "R4 rewrite restarts window");
    ticks(1);  rd_chk(F_CNT, 1, "R4 step after restart");
    ticks(60); rd_chk(F_STAT, 8'h10, "R5 minute expiry fires");
    wr(F_STAT, 8'h00);
  endtask

  task automatic t_force_rst();
    int n;
    wr(F_CTRL, 8'hF2);
    rd_chk(F_CTRL, 8'h02, "R11 ctrl unused bits dropped");
    wr(F_CNT, 8'd10);
    @(negedge clk_i);
    cfg_idx_i = F_STAT; cfg_wdata_i = 8'h20; cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    n = 0;
    while (kbd_rst_o && n < 20) begin n++; @(negedge clk_i); end
    check("R8 reset pulse length", n, 4);
    rd_chk(F_CNT, 0, "R7 force zeroes count");
    rd_chk(F_STAT, 8'h10, "R7 force sets fired, bit5 reads 0");
    wr(F_STAT, 8'h00);
  endtask

  task automatic t_p20();
    wr(F_CTRL, 8'h00);
    wr(F_CNT, 8'd5);
    pulse_in(kbd_p20_i);
    rd_chk(F_CNT, 5, "R9 p20 ignored when disabled");
    rd_chk(F_STAT, 8'h00, "R9 no fired when disabled");
    wr(F_CTRL, 8'h04);
    pulse_in(kbd_p20_i);
    rd_chk(F_CNT, 0, "R9 p20 forces timeout");
    rd_chk(F_STAT, 8'h10, "R9 p20 sets fired");
    wr(F_STAT, 8'h00);
  endtask

  task automatic t_periph();
    wr(F_CTRL, 8'h00);
    wr(F_STAT, 8'h40);
    wr(F_CNT, 8'd4);
    ticks(2);
    pulse_in(kbd_irq_i);
    rd_chk(F_CNT, 4, "R10 keyboard reload");
    ticks(1);
    pulse_in(mouse_irq_i);
    rd_chk(F_CNT, 3, "R10 mouse ignored when disabled");
    wr(F_STAT, 8'h82);
    pulse_in(mouse_irq_i);
    rd_chk(F_CNT, 4, "R10 mouse reload");
    rd_chk(F_STAT, 8'h82, "R11 status readback");
    check("R11 irq select output", wdt_irq_sel_o, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_seconds();
    t_sticky();
    t_disable_reload();
    t_minute();
    t_force_rst();
    t_p20();
    t_periph();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule